// File: doc/BRIEF.md
# Atomic Swap Memory Sequencer

This block carries out one register-to-memory exchange for a processor pipeline. It recognises an exchange instruction word and uses the base register as the address. It reads the old memory value, then writes the source register value to the same address. After that it returns the old value to the destination register. A bus lock is held from the first cycle of the read until the write has been accepted, so the memory arbiter can grant no other master in between. This makes the exchange usable as a semaphore primitive.

The register file, the condition evaluator, the arbiter and the cache all sit outside the block. The block presents the decoded register indices and the condition field combinationally, so that the neighbours can supply the base and source values and a condition-pass verdict in the issue cycle. The read carries a non-cacheable flag, so it always reaches external memory. The write carries a hint telling the cache to refresh a line it already holds. A single instruction bit selects a full-word exchange or a single-byte exchange. A memory abort on either access ends the sequence without touching the destination register.

Top module: `swp_engine`

## Requirements
- R1: `swp_hit` is high exactly when instr[27:23]=00010, instr[21:20]=00 and instr[11:4]=00001001. Any other word presented with `issue_valid` is not accepted: `busy` stays low and no memory request appears.
- R2: The outputs `base_idx`=instr[19:16], `src_idx`=instr[3:0] and `cond_field`=instr[31:28] are driven combinationally. The destination index instr[15:12] appears on `rd_idx` during write-back.
- R3: A recognised word issued with `cond_pass` low causes no memory request, no `busy` and no `done`.
- R4: After acceptance, a read (`mem_we`=0) at the captured base address is requested first, then a write (`mem_we`=1) to the same address. `mem_lock` is high in every cycle that `mem_req` is high, and it drops in the cycle after the write completes. The address and direction hold while `mem_ready` is low.
- R5: With instr[22]=1 (byte), `mem_byte` is high and `mem_wdata` carries the source's bits 7..0 copied into all four byte lanes. The destination receives mem_rdata[7:0] with bits 31..8 cleared.
- R6: With instr[22]=0 (word), `mem_byte` is low, `mem_wdata` equals the full source value, and the destination receives the full read word.
- R7: If `mem_abort` accompanies `mem_ready` on the read, no write is requested. An abort on either access leaves `rd_we` low. `done` still pulses.
- R8: The store data and address are captured in the accept cycle. Later changes on `src_data`/`base_data`, including a destination that equals the source, do not alter the written value.
- R9: During the read `mem_nocache`=1 and `mem_cache_upd`=0. During the write `mem_cache_upd`=1 and `mem_nocache`=0.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse, and on success it coincides with `rd_we`. With zero-wait memory, `done` appears two cycles after the accept edge, and each wait cycle on either access adds one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word presented |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | External condition evaluator verdict |
| cond_field | output | 4 | Condition field for the evaluator |
| base_idx | output | 4 | Base register read index |
| src_idx | output | 4 | Source register read index |
| base_data | input | DATA_W | Base register value (address) |
| src_data | input | DATA_W | Source register value (store data) |
| swp_hit | output | 1 | Word decodes as an exchange |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_wdata | output | DATA_W | Destination write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | Byte-sized access |
| mem_addr | output | DATA_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_abort | input | 1 | Access faulted (valid with mem_ready) |
| mem_lock | output | 1 | Bus lock to the arbiter |
| mem_nocache | output | 1 | Bypass cache for this access |
| mem_cache_upd | output | 1 | Cache should refresh a present line |

## Verification
The bound checker watches the bus protocol on every cycle. It confirms that the lock covers each request and carries over from a successful read into the write. It also checks that a write never starts without a completed read, and that the cache flags match the access direction. It further checks that no write-back follows an abort, that a byte result has clear upper bits, and that `done` lasts one cycle. The data values written and returned, the capture of the source at acceptance, the rejection of non-matching and condition-failed words, and the exact completion latency under different wait patterns can only be shown by the bench's scenarios against its scoreboard.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 4;
    localparam int COND_W    = 4;
    localparam int LANE_W    = 8;

    // fixed opcode fragments that identify the exchange instruction
    localparam logic [4:0] OPC_UPPER = 5'b00010;
    localparam logic [1:0] OPC_PAD   = 2'b00;
    localparam logic [7:0] OPC_LOWER = 8'b0000_1001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } swp_state_e;

    typedef struct packed {
        logic                 hit;
        logic                 byte_op;
        logic [COND_W-1:0]    cond;
        logic [REG_IDX_W-1:0] base_reg;
        logic [REG_IDX_W-1:0] dst_reg;
        logic [REG_IDX_W-1:0] src_reg;
    } swp_decode_t;

    typedef struct packed {
        logic req;
        logic we;
        logic lock;
        logic nocache;
        logic cache_upd;
    } swp_bus_ctl_t;

    function automatic swp_decode_t swp_decode(input logic [INSTR_W-1:0] w);
        swp_decode_t d;
        d.hit      = (w[27:23] == OPC_UPPER) &&
                     (w[21:20] == OPC_PAD)   &&
                     (w[11:4]  == OPC_LOWER);
        d.byte_op  = w[22];
        d.cond     = w[31:28];
        d.base_reg = w[19:16];
        d.dst_reg  = w[15:12];
        d.src_reg  = w[3:0];
        return d;
    endfunction

endpackage

// File: rtl/swp_decoder.sv
module swp_decoder
    import swp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output swp_decode_t        dec
);

    always_comb begin
        dec = swp_decode(instr);
    end

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
    import swp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mem_ready,
    input  logic         mem_abort,
    output swp_bus_ctl_t bus,
    output logic         busy,
    output logic         done,
    output logic         wb_en,
    output logic         load_rd
);

    swp_state_e state_q, state_d;
    logic       fail_q, fail_d;

    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_READ;
                    fail_d  = 1'b0;
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    if (mem_abort) begin
                        state_d = ST_FINISH;
                        fail_d  = 1'b1;
                    end else begin
                        state_d = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    state_d = ST_FINISH;
                    fail_d  = mem_abort;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    always_comb begin
        bus.req       = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus.we        = (state_q == ST_WRITE);
        bus.lock      = bus.req;
        bus.nocache   = (state_q == ST_READ);
        bus.cache_upd = (state_q == ST_WRITE);
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_FINISH);
        wb_en         = (state_q == ST_FINISH) && !fail_q;
        load_rd       = (state_q == ST_READ) && mem_ready && !mem_abort;
    end

endmodule

// File: rtl/swp_datapath.sv
module swp_datapath
    import swp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 byte_op,
    input  logic [REG_IDX_W-1:0] dst_reg,
    input  logic [DATA_W-1:0]    base_data,
    input  logic [DATA_W-1:0]    src_data,
    input  logic                 load_rd,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_byte,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_wdata
);

    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0]    addr_q;
    logic [DATA_W-1:0]    store_q;
    logic                 byte_q;
    logic [REG_IDX_W-1:0] dst_q;
    logic [DATA_W-1:0]    result_q;
    logic [DATA_W-1:0]    lane_rep;
    logic [DATA_W-1:0]    fetched;

    // operands are frozen at acceptance so a later register update cannot leak in
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            store_q <= '0;
            byte_q  <= 1'b0;
            dst_q   <= '0;
        end else if (start) begin
            addr_q  <= base_data;
            store_q <= src_data;
            byte_q  <= byte_op;
            dst_q   <= dst_reg;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_rep[g*LANE_W +: LANE_W] = store_q[LANE_W-1:0];
        end
    endgenerate

    always_comb begin
        if (byte_q) begin
            fetched = {{(DATA_W-LANE_W){1'b0}}, mem_rdata[LANE_W-1:0]};
        end else begin
            fetched = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (load_rd) begin
            result_q <= fetched;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = byte_q ? lane_rep : store_q;
    assign mem_byte  = byte_q;
    assign rd_idx    = dst_q;
    assign rd_wdata  = result_q;

endmodule

// File: rtl/swp_engine.sv
module swp_engine
    import swp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 cond_pass,
    output logic [COND_W-1:0]    cond_field,
    output logic [REG_IDX_W-1:0] base_idx,
    output logic [REG_IDX_W-1:0] src_idx,
    input  logic [DATA_W-1:0]    base_data,
    input  logic [DATA_W-1:0]    src_data,
    output logic                 swp_hit,
    output logic                 busy,
    output logic                 done,
    output logic                 rd_we,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_byte,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    input  logic                 mem_abort,
    output logic                 mem_lock,
    output logic                 mem_nocache,
    output logic                 mem_cache_upd
);

    swp_decode_t  dec;
    swp_bus_ctl_t bus;
    logic         start;
    logic         load_rd;

    swp_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign start = issue_valid && dec.hit && cond_pass && !busy;

    swp_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ready (mem_ready),
        .mem_abort (mem_abort),
        .bus       (bus),
        .busy      (busy),
        .done      (done),
        .wb_en     (rd_we),
        .load_rd   (load_rd)
    );

    swp_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_op   (dec.byte_op),
        .dst_reg   (dec.dst_reg),
        .base_data (base_data),
        .src_data  (src_data),
        .load_rd   (load_rd),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_byte  (mem_byte),
        .rd_idx    (rd_idx),
        .rd_wdata  (rd_wdata)
    );

    assign cond_field    = dec.cond;
    assign base_idx      = dec.base_reg;
    assign src_idx       = dec.src_reg;
    assign swp_hit       = dec.hit;
    assign mem_req       = bus.req;
    assign mem_we        = bus.we;
    assign mem_lock      = bus.lock;
    assign mem_nocache   = bus.nocache;
    assign mem_cache_upd = bus.cache_upd;

endmodule

// File: rtl/swp_engine_chk.sv
module swp_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              rd_we,
    input logic [DATA_W-1:0] rd_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              mem_abort,
    input logic              mem_lock,
    input logic              mem_nocache,
    input logic              mem_cache_upd
);

    logic read_ok_seen;
    logic abort_seen;
    logic byte_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            read_ok_seen <= 1'b0;
            abort_seen   <= 1'b0;
            byte_seen    <= 1'b0;
        end else if (done) begin
            read_ok_seen <= 1'b0;
            abort_seen   <= 1'b0;
            byte_seen    <= 1'b0;
        end else if (mem_req && mem_ready) begin
            if (mem_abort) abort_seen <= 1'b1;
            if (!mem_we && !mem_abort) begin
                read_ok_seen <= 1'b1;
                byte_seen    <= mem_byte;
            end
        end
    end

    AST_LOCK_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);  // R4

    AST_LOCK_CARRIES_TO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !mem_we && !mem_abort) |=> (mem_req && mem_we && mem_lock));  // R4

    AST_SAME_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !mem_we && !mem_abort) |=> $stable(mem_addr));  // R4

    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> read_ok_seen);  // R7

    AST_NO_WB_AFTER_ABORT: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> !abort_seen);  // R7

    AST_BYTE_ZERO_UPPER: assert property (@(posedge clk) disable iff (rst)
        (rd_we && byte_seen) |-> (rd_wdata[DATA_W-1:8] == '0));  // R5

    AST_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_nocache && !mem_cache_upd));  // R9

    AST_WRITE_HINT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_cache_upd && !mem_nocache));  // R9

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);  // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R10

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> (done && busy));  // R10

endmodule

bind swp_engine swp_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .rd_we         (rd_we),
    .rd_wdata      (rd_wdata),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_byte      (mem_byte),
    .mem_addr      (mem_addr),
    .mem_ready     (mem_ready),
    .mem_abort     (mem_abort),
    .mem_lock      (mem_lock),
    .mem_nocache   (mem_nocache),
    .mem_cache_upd (mem_cache_upd)
);

// File: tb/tb_swp_engine.sv
`timescale 1ns/1ps
module tb_swp_engine;
    import swp_pkg::*;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic          cond_pass = 1'b0;
    logic [3:0]    cond_field, base_idx, src_idx, rd_idx;
    logic [DW-1:0] base_data = '0, src_data = '0;
    logic          swp_hit, busy, done, rd_we;
    logic [DW-1:0] rd_wdata, mem_addr, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_req, mem_we, mem_byte, mem_lock, mem_nocache, mem_cache_upd;
    logic          mem_ready = 1'b0, mem_abort = 1'b0;

    always #2.5 clk = ~clk;

    swp_engine #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
        .cond_pass(cond_pass), .cond_field(cond_field), .base_idx(base_idx),
        .src_idx(src_idx), .base_data(base_data), .src_data(src_data),
        .swp_hit(swp_hit), .busy(busy), .done(done), .rd_we(rd_we),
        .rd_idx(rd_idx), .rd_wdata(rd_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_abort(mem_abort),
        .mem_lock(mem_lock), .mem_nocache(mem_nocache), .mem_cache_upd(mem_cache_upd)
    );

    typedef struct { logic we; logic [3:0] idx; logic [DW-1:0] data; int dcyc; } rd_exp_t;
    typedef struct { logic [DW-1:0] addr; logic [DW-1:0] data; logic byt; } wr_exp_t;

    rd_exp_t       rdq[$];
    wr_exp_t       wrq[$];
    int            nchk = 0, nfail = 0, cyc = 0, lat = 0, cnt = 0;
    bit            ab_rd = 0, ab_wr = 0, finished = 0;
    logic [DW-1:0] mem_val = '0, rd_addr_exp = '0;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit byt, input logic [3:0] rn,
                                       input logic [3:0] rd, input logic [3:0] rm);
        return {4'hE, 5'b00010, byt, 2'b00, rn, rd, 8'b0000_1001, rm};
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            nfail++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // memory responder: completes each access after lat wait cycles
    always @(negedge clk) begin
        wr_exp_t e;
        mem_ready = 1'b0;
        mem_abort = 1'b0;
        if (rst || !mem_req) begin
            cnt = 0;
        end else if (cnt >= lat) begin
            cnt = 0;
            mem_ready = 1'b1;
            check(mem_lock, "R4 lock during access", {31'b0, mem_lock}, 1);
            if (mem_we) begin
                mem_abort = ab_wr;
                check(mem_cache_upd && !mem_nocache, "R9 write hint",
                      {30'b0, mem_cache_upd, mem_nocache}, 2);
                if (wrq.size() == 0) begin
                    check(0, "R7 unexpected write", mem_addr, 0);
                end else begin
                    e = wrq.pop_front();
                    check(mem_addr == e.addr, "R4 write address", mem_addr, e.addr);
                    check(mem_wdata == e.data, e.byt ? "R5 byte store data R8" : "R6 word store data R8",
                          mem_wdata, e.data);
                    check(mem_byte == e.byt, "R5 size flag", {31'b0, mem_byte}, {31'b0, e.byt});
                end
            end else begin
                mem_abort = ab_rd;
                mem_rdata = mem_val;
                check(mem_nocache && !mem_cache_upd, "R9 read bypass",
                      {30'b0, mem_cache_upd, mem_nocache}, 1);
                check(mem_addr == rd_addr_exp, "R4 read address", mem_addr, rd_addr_exp);
            end
        end else begin
            cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        rd_exp_t e;
        if (!rst && done) begin
            if (rdq.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                e = rdq.pop_front();
                check(rd_we == e.we, "R7 write-back enable", {31'b0, rd_we}, {31'b0, e.we});
                check(cyc == e.dcyc, "R10 completion cycle", cyc, e.dcyc);
                check(!mem_lock && busy, "R4 lock released, busy held",
                      {30'b0, mem_lock, busy}, 1);
                if (e.we) begin
                    check(rd_idx == e.idx, "R2 destination index", {28'b0, rd_idx}, {28'b0, e.idx});
                    check(rd_wdata == e.data, "R5 R6 returned value", rd_wdata, e.data);
                end
            end
        end
    end

    task automatic run_swap(input bit byt, input logic [3:0] rn, input logic [3:0] rd,
                            input logic [3:0] rm, input logic [DW-1:0] base,
                            input logic [DW-1:0] src, input logic [DW-1:0] mval,
                            input int l, input bit ar, input bit aw);
        rd_exp_t r;
        wr_exp_t w;
        int      acc;
        @(negedge clk);
        while (busy) @(negedge clk);
        lat = l; ab_rd = ar; ab_wr = aw; mem_val = mval; rd_addr_exp = base;
        instr = mk(byt, rn, rd, rm);
        cond_pass = 1'b1; issue_valid = 1'b1; base_data = base; src_data = src;
        #0.5;
        check(swp_hit, "R1 exchange recognised", {31'b0, swp_hit}, 1);
        check(base_idx == rn && src_idx == rm && cond_field == 4'hE, "R2 index outputs",
              {20'b0, cond_field, base_idx, src_idx}, {20'b0, 4'hE, rn, rm});
        if (!ar) begin
            w.addr = base; w.byt = byt;
            w.data = byt ? {4{src[7:0]}} : src;
            wrq.push_back(w);
        end
        @(posedge clk);
        #1;
        acc = cyc;
        issue_valid = 1'b0;
        base_data = ~base;
        src_data = ~src;  // R8: must not reach the store
        check(busy, "R10 busy after accept", {31'b0, busy}, 1);
        r.we = !ar && !aw; r.idx = rd;
        r.data = byt ? {24'b0, mval[7:0]} : mval;
        r.dcyc = ar ? acc + 1 + l : acc + 2 + 2 * l;
        rdq.push_back(r);
        while (rdq.size() != 0) @(negedge clk);
        @(negedge clk);
        check(wrq.size() == 0, "R7 pending write count", wrq.size(), 0);
    endtask

    task automatic expect_ignored(input logic [31:0] word, input bit cp, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        instr = word; cond_pass = cp; issue_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!busy && !mem_req && !done, tag, {29'b0, busy, mem_req, done}, 0);
        end
        issue_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req && !mem_lock && !rd_we, "R10 reset state",
              {27'b0, busy, done, mem_req, mem_lock, rd_we}, 0);

        // word exchange, zero wait
        run_swap(0, 4'd1, 4'd2, 4'd3, 32'h0000_1000, 32'hCAFE_F00D, 32'h1234_5678, 0, 0, 0);
        // byte exchange with waits, upper read bits must be dropped
        run_swap(1, 4'd4, 4'd5, 4'd6, 32'h0000_2003, 32'h1234_56C7, 32'hA5A5_5A3C, 2, 0, 0);
        // destination equals source: old register value stored
        run_swap(0, 4'd7, 4'd8, 4'd8, 32'h0000_3000, 32'h0BAD_BEEF, 32'h7777_0001, 1, 0, 0);
        // abort on the read: no write, no write-back
        run_swap(0, 4'd9, 4'd10, 4'd11, 32'h0000_4000, 32'h1111_2222, 32'h3333_4444, 1, 1, 0);
        // abort on the write: no write-back
        run_swap(1, 4'd12, 4'd13, 4'd14, 32'h0000_5001, 32'h0000_00AB, 32'hFFFF_FF5E, 0, 0, 1);
        // longer waits, word
        run_swap(0, 4'd0, 4'd15, 4'd1, 32'hFFFF_FFFC, 32'h8000_0001, 32'hDEAD_0000, 3, 0, 0);

        // R1: one opcode bit wrong, not accepted
        expect_ignored(mk(0, 4'd1, 4'd2, 4'd3) ^ 32'h0000_0080, 1, "R1 non-matching word ignored");
        #0.5;
        check(!swp_hit, "R1 hit low on non-matching word", {31'b0, swp_hit}, 0);
        expect_ignored(mk(0, 4'd1, 4'd2, 4'd3) ^ 32'h0010_0000, 1, "R1 pad bits nonzero ignored");
        // R3: condition fails
        expect_ignored(mk(1, 4'd1, 4'd2, 4'd3), 0, "R3 condition fail no bus activity");

        // still functional afterwards
        run_swap(1, 4'd2, 4'd3, 4'd4, 32'h0000_6002, 32'h0000_0099, 32'h0102_0380, 0, 0, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule